// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This block moves outgoing packet data from memory to a byte stream under the control of a ring of buffer descriptors. Software writes descriptors into local storage. Each descriptor is three 32-bit words: a status word that holds a byte count and control flags, then the low and high halves of a 64-bit buffer address. Software then moves a free-running 16-bit producer index forward. While its enables are on, the engine compares its own 16-bit consumer index with the producer index. For each pending descriptor it reads the buffer one byte at a time through a simple request/response port and presents the bytes on a valid/ready stream, marking the start and end of the packet. It then writes the closed status back into the descriptor and moves the consumer index forward.

The ring slot is the consumer index modulo the ring depth (256 by default). A packet may span several descriptors. The start marker comes from the descriptor that carries the start flag, and the last marker comes from the descriptor that carries the end flag. Software can load the consumer index directly while the engine is idle, which is how the ring is set up. It reads the consumer index back to reclaim finished descriptors. If the downstream sink holds off a byte for too long, the engine records this in the descriptor and still finishes the packet.

Top module: `txring_dma`

## Requirements
- R1: After reset the consumer index reads 0, and `tx_valid`, `tx_sop`, `tx_last` and `rd_req_valid` are low.
- R2: Software writes descriptor words through the write port and reads them through the read port. Word select 0 is the status word, 1 is address bits 31:0 and 2 is address bits 63:32. The byte count is status bits 27:16. The engine issues one read request per byte, at addresses base, base+1, … base+count−1, and streams the returned bytes in that order.
- R3: The engine works whenever the consumer index differs from the producer index (16-bit, modulo 65536). After a descriptor's last byte has been accepted, it adds exactly one to the consumer index.
- R4: The descriptor slot used is the consumer index modulo 256. Slot 255 is followed by slot 0, and consumer index 65535 is followed by 0.
- R5: `tx_sop` is high only with the first byte of a descriptor whose status bit 13 is set. `tx_last` is high only with the final byte of a descriptor whose status bit 14 is set.
- R6: While the global enable `dma_en` or the ring enable `ring_en` is low, no new descriptor is fetched: there are no read requests and the consumer index stays put. Pending work starts once both enables are high.
- R7: If a byte waits on the stream with `tx_ready` low for `stall_limit` consecutive cycles (`stall_limit` nonzero), the engine sets status bit 9 (underrun) when it writes the descriptor back. The packet still completes in full. A shorter stall leaves bit 9 clear.
- R8: On completion the engine clears status bit 15 (owner) and leaves the byte count and the other flag bits as software wrote them.
- R9: A descriptor with a byte count of 0 produces no read request and no stream byte. It is still written back with bit 15 cleared, and the consumer index still advances.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and the markers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_en | input | 1 | Global engine enable |
| ring_en | input | 1 | Enable for this ring |
| stall_limit | input | 16 | Sink stall cycles that mark an underrun (0 disables) |
| desc_wr_en | input | 1 | Descriptor word write strobe |
| desc_wr_slot | input | 8 | Slot to write |
| desc_wr_word | input | 2 | Word select: 0 status, 1 address low, 2 address high |
| desc_wr_data | input | 32 | Word value |
| desc_rd_slot | input | 8 | Slot to read back |
| desc_rd_word | input | 2 | Word select for read back |
| desc_rd_data | output | 32 | Selected descriptor word |
| prod_wr_en | input | 1 | Producer index write strobe |
| prod_wr_data | input | 16 | New producer index |
| cons_wr_en | input | 1 | Consumer index load strobe (ring set-up) |
| cons_wr_data | input | 16 | Consumer index load value |
| cons_idx | output | 16 | Current consumer index |
| rd_req_valid | output | 1 | Buffer byte read request (one cycle) |
| rd_req_addr | output | 64 | Byte address of the request |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_data | input | 8 | Read response byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Sink accepts byte |
| tx_data | output | 8 | Stream byte |
| tx_sop | output | 1 | First byte of packet |
| tx_last | output | 1 | Final byte of packet |

## Verification
The bench puts four descriptors across the 255→0 slot boundary and the 65535→0 index boundary. An engine that uses the wrong index bits for the slot, or that compares indices with "less than" instead of "not equal", would fetch the wrong slots or stall at the wrap. It splits a packet over two descriptors, so a design that raises the start or last marker on every descriptor would produce extra markers. It holds the sink off for longer and for shorter than the limit: an off-by-one stall counter would set or miss the underrun bit, and a design that drops the packet on underrun would lose bytes. It also sends a zero-length descriptor and a descriptor that waits while the engine is disabled. Both catch engines that stream a phantom byte, never advance, or fetch while disabled.

// File: rtl/txring_pkg.sv
package txring_pkg;

    // Descriptor word selection
    localparam logic [1:0] WSEL_STATUS  = 2'd0;
    localparam logic [1:0] WSEL_ADDR_LO = 2'd1;
    localparam logic [1:0] WSEL_ADDR_HI = 2'd2;

    // Status word layout
    localparam int CNT_LSB      = 16;
    localparam int CNT_W        = 12;
    localparam int FLAG_OWNER   = 15;
    localparam int FLAG_END     = 14;
    localparam int FLAG_START   = 13;
    localparam int FLAG_UNDERRUN = 9;

    typedef struct packed {
        logic [31:0] addr_hi;
        logic [31:0] addr_lo;
        logic [31:0] status;
    } desc_t;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_FETCH,
        ENG_REQ,
        ENG_WAIT,
        ENG_SEND,
        ENG_CLOSE
    } eng_state_e;

    function automatic logic [CNT_W-1:0] byte_count(input logic [31:0] st);
        return st[CNT_LSB +: CNT_W];
    endfunction

    // Status as written back on completion
    function automatic logic [31:0] closed_status(input logic [31:0] st, input logic under);
        logic [31:0] r;
        r = st;
        r[FLAG_OWNER] = 1'b0;
        if (under) r[FLAG_UNDERRUN] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/txring_desc_store.sv
module txring_desc_store
    import txring_pkg::*;
#(
    parameter int SLOTS  = 256,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    // software side
    input  logic              sw_wr_en,
    input  logic [SLOT_W-1:0] sw_wr_slot,
    input  logic [1:0]        sw_wr_word,
    input  logic [31:0]       sw_wr_data,
    input  logic [SLOT_W-1:0] sw_rd_slot,
    input  logic [1:0]        sw_rd_word,
    output logic [31:0]       sw_rd_data,
    // engine side
    input  logic [SLOT_W-1:0] eng_slot,
    output desc_t             eng_desc,
    input  logic              wb_en,
    input  logic [SLOT_W-1:0] wb_slot,
    input  logic [31:0]       wb_status
);

    desc_t mem [SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (wb_en) begin
                mem[wb_slot].status <= wb_status;
            end
            // a software write to the same word in the same cycle takes precedence
            if (sw_wr_en) begin
                case (sw_wr_word)
                    WSEL_STATUS:  mem[sw_wr_slot].status  <= sw_wr_data;
                    WSEL_ADDR_LO: mem[sw_wr_slot].addr_lo <= sw_wr_data;
                    WSEL_ADDR_HI: mem[sw_wr_slot].addr_hi <= sw_wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (sw_rd_word)
            WSEL_STATUS:  sw_rd_data = mem[sw_rd_slot].status;
            WSEL_ADDR_LO: sw_rd_data = mem[sw_rd_slot].addr_lo;
            WSEL_ADDR_HI: sw_rd_data = mem[sw_rd_slot].addr_hi;
            default:      sw_rd_data = '0;
        endcase
    end

    assign eng_desc = mem[eng_slot];

endmodule

// File: rtl/txring_index.sv
module txring_index #(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prod_wr_en,
    input  logic [IDX_W-1:0] prod_wr_data,
    input  logic             cons_wr_en,
    input  logic [IDX_W-1:0] cons_wr_data,
    input  logic             cons_inc,
    output logic [IDX_W-1:0] prod_idx,
    output logic [IDX_W-1:0] cons_idx,
    output logic             pending
);

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_idx <= '0;
            cons_idx <= '0;
        end else begin
            if (prod_wr_en) prod_idx <= prod_wr_data;
            if (cons_wr_en)      cons_idx <= cons_wr_data;
            else if (cons_inc)   cons_idx <= cons_idx + 1'b1;
        end
    end

    assign pending = (cons_idx != prod_idx);

    AST_CONS_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(cons_wr_en) |-> (cons_idx == $past(cons_idx) || cons_idx == $past(cons_idx) + 1'b1)); // R3

    AST_CONS_MOVES_ON_INC: assert property (@(posedge clk) disable iff (rst)
        (cons_inc && !cons_wr_en) |=> (cons_idx != $past(cons_idx))); // R4

endmodule

// File: rtl/txring_engine.sv
module txring_engine
    import txring_pkg::*;
#(
    parameter int SLOT_W  = 8,
    parameter int IDX_W   = 16,
    parameter int ADDR_W  = 64,
    parameter int STALL_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dma_en,
    input  logic               ring_en,
    input  logic [STALL_W-1:0] stall_limit,
    input  logic               pending,
    input  logic [IDX_W-1:0]   cons_idx,
    output logic [SLOT_W-1:0]  fetch_slot,
    input  desc_t              desc_in,
    output logic               wb_en,
    output logic [SLOT_W-1:0]  wb_slot,
    output logic [31:0]        wb_status,
    output logic               cons_inc,
    output logic               rd_req_valid,
    output logic [ADDR_W-1:0]  rd_req_addr,
    input  logic               rd_rsp_valid,
    input  logic [7:0]         rd_rsp_data,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [7:0]         tx_data,
    output logic               tx_sop,
    output logic               tx_last
);

    eng_state_e         st;
    logic [SLOT_W-1:0]  slot_q;
    logic [31:0]        status_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [CNT_W-1:0]   left_q;
    logic               first_q;
    logic               under_q;
    logic [STALL_W-1:0] stall_q;
    logic [7:0]         data_q;

    logic               go;
    logic [CNT_W-1:0]   fetch_cnt;
    logic               final_byte;
    logic [STALL_W:0]   stall_next;

    assign go         = dma_en && ring_en && pending;
    assign fetch_slot = cons_idx[SLOT_W-1:0];
    assign fetch_cnt  = byte_count(desc_in.status);
    assign final_byte = (left_q == CNT_W'(1));
    assign stall_next = {1'b0, stall_q} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ENG_IDLE;
            slot_q   <= '0;
            status_q <= '0;
            addr_q   <= '0;
            left_q   <= '0;
            first_q  <= 1'b0;
            under_q  <= 1'b0;
            stall_q  <= '0;
            data_q   <= '0;
        end else begin
            case (st)
                ENG_IDLE: begin
                    if (go) st <= ENG_FETCH;
                end
                ENG_FETCH: begin
                    slot_q   <= fetch_slot;
                    status_q <= desc_in.status;
                    addr_q   <= ADDR_W'({desc_in.addr_hi, desc_in.addr_lo});
                    left_q   <= fetch_cnt;
                    first_q  <= 1'b1;
                    under_q  <= 1'b0;
                    st       <= (fetch_cnt == '0) ? ENG_CLOSE : ENG_REQ;
                end
                ENG_REQ: begin
                    st <= ENG_WAIT;
                end
                ENG_WAIT: begin
                    if (rd_rsp_valid) begin
                        data_q  <= rd_rsp_data;
                        stall_q <= '0;
                        st      <= ENG_SEND;
                    end
                end
                ENG_SEND: begin
                    if (tx_ready) begin
                        first_q <= 1'b0;
                        left_q  <= left_q - 1'b1;
                        addr_q  <= addr_q + 1'b1;
                        st      <= final_byte ? ENG_CLOSE : ENG_REQ;
                    end else begin
                        if (stall_q != '1) stall_q <= stall_q + 1'b1;
                        if (stall_limit != '0 && stall_next >= {1'b0, stall_limit})
                            under_q <= 1'b1;
                    end
                end
                ENG_CLOSE: begin
                    st <= ENG_IDLE;
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end

    assign rd_req_valid = (st == ENG_REQ);
    assign rd_req_addr  = addr_q;

    assign tx_valid = (st == ENG_SEND);
    assign tx_data  = data_q;
    assign tx_sop   = (st == ENG_SEND) && first_q && status_q[FLAG_START];
    assign tx_last  = (st == ENG_SEND) && final_byte && status_q[FLAG_END];

    assign wb_en     = (st == ENG_CLOSE);
    assign wb_slot   = slot_q;
    assign wb_status = closed_status(status_q, under_q);
    assign cons_inc  = (st == ENG_CLOSE);

    AST_NO_FETCH_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (st == ENG_IDLE && !(dma_en && ring_en)) |=> (st == ENG_IDLE)); // R6

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_sop))); // R10

    AST_MARKERS_NEED_VALID: assert property (@(posedge clk) disable iff (rst)
        (tx_sop || tx_last) |-> tx_valid); // R5

    AST_SINGLE_REQUEST: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |=> !rd_req_valid); // R2

    AST_NO_STREAM_BEFORE_RSP: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> $past(rd_rsp_valid)); // R9

endmodule

// File: rtl/txring_dma.sv
module txring_dma
    import txring_pkg::*;
#(
    parameter int SLOTS   = 256,
    parameter int IDX_W   = 16,
    parameter int STALL_W = 16,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int ADDR_W = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dma_en,
    input  logic               ring_en,
    input  logic [STALL_W-1:0] stall_limit,
    input  logic               desc_wr_en,
    input  logic [SLOT_W-1:0]  desc_wr_slot,
    input  logic [1:0]         desc_wr_word,
    input  logic [31:0]        desc_wr_data,
    input  logic [SLOT_W-1:0]  desc_rd_slot,
    input  logic [1:0]         desc_rd_word,
    output logic [31:0]        desc_rd_data,
    input  logic               prod_wr_en,
    input  logic [IDX_W-1:0]   prod_wr_data,
    input  logic               cons_wr_en,
    input  logic [IDX_W-1:0]   cons_wr_data,
    output logic [IDX_W-1:0]   cons_idx,
    output logic               rd_req_valid,
    output logic [ADDR_W-1:0]  rd_req_addr,
    input  logic               rd_rsp_valid,
    input  logic [7:0]         rd_rsp_data,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [7:0]         tx_data,
    output logic               tx_sop,
    output logic               tx_last
);

    logic [IDX_W-1:0]  prod_idx;
    logic              pending;
    logic              cons_inc;
    logic [SLOT_W-1:0] fetch_slot;
    desc_t             fetch_desc;
    logic              wb_en;
    logic [SLOT_W-1:0] wb_slot;
    logic [31:0]       wb_status;

    txring_index #(.IDX_W(IDX_W)) u_index (
        .clk          (clk),
        .rst          (rst),
        .prod_wr_en   (prod_wr_en),
        .prod_wr_data (prod_wr_data),
        .cons_wr_en   (cons_wr_en),
        .cons_wr_data (cons_wr_data),
        .cons_inc     (cons_inc),
        .prod_idx     (prod_idx),
        .cons_idx     (cons_idx),
        .pending      (pending)
    );

    txring_desc_store #(.SLOTS(SLOTS)) u_store (
        .clk        (clk),
        .rst        (rst),
        .sw_wr_en   (desc_wr_en),
        .sw_wr_slot (desc_wr_slot),
        .sw_wr_word (desc_wr_word),
        .sw_wr_data (desc_wr_data),
        .sw_rd_slot (desc_rd_slot),
        .sw_rd_word (desc_rd_word),
        .sw_rd_data (desc_rd_data),
        .eng_slot   (fetch_slot),
        .eng_desc   (fetch_desc),
        .wb_en      (wb_en),
        .wb_slot    (wb_slot),
        .wb_status  (wb_status)
    );

    txring_engine #(
        .SLOT_W  (SLOT_W),
        .IDX_W   (IDX_W),
        .ADDR_W  (ADDR_W),
        .STALL_W (STALL_W)
    ) u_engine (
        .clk          (clk),
        .rst          (rst),
        .dma_en       (dma_en),
        .ring_en      (ring_en),
        .stall_limit  (stall_limit),
        .pending      (pending),
        .cons_idx     (cons_idx),
        .fetch_slot   (fetch_slot),
        .desc_in      (fetch_desc),
        .wb_en        (wb_en),
        .wb_slot      (wb_slot),
        .wb_status    (wb_status),
        .cons_inc     (cons_inc),
        .rd_req_valid (rd_req_valid),
        .rd_req_addr  (rd_req_addr),
        .rd_rsp_valid (rd_rsp_valid),
        .rd_rsp_data  (rd_rsp_data),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .tx_data      (tx_data),
        .tx_sop       (tx_sop),
        .tx_last      (tx_last)
    );

    AST_IDLE_WHEN_DRAINED: assert property (@(posedge clk) disable iff (rst)
        (!pending && !tx_valid && !rd_req_valid && !cons_inc) |=> !rd_req_valid); // R3

endmodule

// File: tb/txring_dma_tb.sv
`timescale 1ns/1ps
module txring_dma_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dma_en = 1'b0;
    logic        ring_en = 1'b0;
    logic [15:0] stall_limit = 16'd0;
    logic        desc_wr_en = 1'b0;
    logic [7:0]  desc_wr_slot = '0;
    logic [1:0]  desc_wr_word = '0;
    logic [31:0] desc_wr_data = '0;
    logic [7:0]  desc_rd_slot = '0;
    logic [1:0]  desc_rd_word = '0;
    logic [31:0] desc_rd_data;
    logic        prod_wr_en = 1'b0;
    logic [15:0] prod_wr_data = '0;
    logic        cons_wr_en = 1'b0;
    logic [15:0] cons_wr_data = '0;
    logic [15:0] cons_idx;
    logic        rd_req_valid;
    logic [63:0] rd_req_addr;
    logic        rd_rsp_valid;
    logic [7:0]  rd_rsp_data;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [7:0]  tx_data;
    logic        tx_sop;
    logic        tx_last;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    txring_dma u_dut (
        .clk(clk), .rst(rst), .dma_en(dma_en), .ring_en(ring_en), .stall_limit(stall_limit),
        .desc_wr_en(desc_wr_en), .desc_wr_slot(desc_wr_slot), .desc_wr_word(desc_wr_word),
        .desc_wr_data(desc_wr_data), .desc_rd_slot(desc_rd_slot), .desc_rd_word(desc_rd_word),
        .desc_rd_data(desc_rd_data), .prod_wr_en(prod_wr_en), .prod_wr_data(prod_wr_data),
        .cons_wr_en(cons_wr_en), .cons_wr_data(cons_wr_data), .cons_idx(cons_idx),
        .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
        .rd_rsp_data(rd_rsp_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_sop(tx_sop), .tx_last(tx_last)
    );

    function automatic logic [7:0] mem_byte(input logic [63:0] a);
        return a[7:0] ^ a[39:32] ^ 8'h5A;
    endfunction

    // memory model: one-cycle response; stream collector
    logic [7:0] cap_data [64];
    logic       cap_sop  [64];
    logic       cap_last [64];
    int         cap_n   = 0;
    int         req_cnt = 0;

    always @(posedge clk) begin
        rd_rsp_valid <= rd_req_valid;
        rd_rsp_data  <= mem_byte(rd_req_addr);
        if (rd_req_valid) req_cnt <= req_cnt + 1;
        if (tx_valid && tx_ready && cap_n < 64) begin
            cap_data[cap_n] <= tx_data;
            cap_sop[cap_n]  <= tx_sop;
            cap_last[cap_n] <= tx_last;
            cap_n <= cap_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    task automatic sw_word(input logic [7:0] slot, input logic [1:0] w, input logic [31:0] d);
        @(negedge clk);
        desc_wr_en = 1'b1; desc_wr_slot = slot; desc_wr_word = w; desc_wr_data = d;
        @(negedge clk);
        desc_wr_en = 1'b0;
    endtask

    // flags: bit2=own, bit1=end, bit0=start
    task automatic put_desc(input logic [7:0] slot, input int cnt, input logic [2:0] fl,
                            input logic [63:0] addr);
        logic [31:0] st;
        st = (32'(cnt) << 16) | (32'(fl[2]) << 15) | (32'(fl[1]) << 14) | (32'(fl[0]) << 13);
        sw_word(slot, 2'd0, st);
        sw_word(slot, 2'd1, addr[31:0]);
        sw_word(slot, 2'd2, addr[63:32]);
    endtask

    task automatic post_prod(input logic [15:0] p);
        @(negedge clk);
        prod_wr_en = 1'b1; prod_wr_data = p;
        @(negedge clk);
        prod_wr_en = 1'b0;
    endtask

    task automatic wait_cons(input logic [15:0] exp, input string req);
        for (int i = 0; i < 2000 && cons_idx != exp; i++) @(negedge clk);
        @(negedge clk);
        check(cons_idx == exp, req, cons_idx, exp);
    endtask

    task automatic read_status(input logic [7:0] slot, output logic [31:0] v);
        @(negedge clk);
        desc_rd_slot = slot; desc_rd_word = 2'd0;
        #1 v = desc_rd_data;
    endtask

    task automatic check_bytes(input int base, input int n, input logic [63:0] addr,
                               input bit sop, input bit eop, input string req);
        for (int i = 0; i < n; i++) begin
            check(cap_data[base+i] == mem_byte(addr + 64'(i)), req, cap_data[base+i], mem_byte(addr + 64'(i)));
            check(cap_sop[base+i] == (sop && i == 0), {req, " sop"}, cap_sop[base+i], (sop && i == 0));
            check(cap_last[base+i] == (eop && i == n-1), {req, " last"}, cap_last[base+i], (eop && i == n-1));
        end
    endtask

    task automatic t_reset();
        check(cons_idx == 16'd0, "R1 cons", cons_idx, 0);
        check(!tx_valid && !tx_sop && !tx_last, "R1 stream", {tx_valid, tx_sop, tx_last}, 0);
        check(!rd_req_valid, "R1 req", rd_req_valid, 0);
    endtask

    task automatic t_single();
        logic [31:0] st;
        int base = cap_n;
        put_desc(8'd0, 5, 3'b111, 64'h0000_0012_0000_1000);
        post_prod(16'd1);
        wait_cons(16'd1, "R3 single advance");
        check(cap_n - base == 5, "R2 byte count", cap_n - base, 5);
        check_bytes(base, 5, 64'h0000_0012_0000_1000, 1'b1, 1'b1, "R2 R5 single");
        read_status(8'd0, st);
        check(st == 32'h0005_6000, "R8 own cleared", st, 32'h0005_6000);
    endtask

    task automatic t_split();
        int base = cap_n;
        put_desc(8'd1, 3, 3'b101, 64'h0000_0000_0000_2000);
        put_desc(8'd2, 2, 3'b110, 64'h0000_0001_0000_3000);
        post_prod(16'd3);
        wait_cons(16'd3, "R3 split advance");
        check(cap_n - base == 5, "R5 split count", cap_n - base, 5);
        check_bytes(base, 3, 64'h0000_0000_0000_2000, 1'b1, 1'b0, "R5 split head");
        check_bytes(base + 3, 2, 64'h0000_0001_0000_3000, 1'b0, 1'b1, "R5 split tail");
    endtask

    task automatic t_disabled();
        int base = cap_n;
        int reqs = req_cnt;
        put_desc(8'd3, 2, 3'b111, 64'h40);
        @(negedge clk); dma_en = 1'b0;
        post_prod(16'd4);
        repeat (30) @(negedge clk);
        check(cons_idx == 16'd3 && req_cnt == reqs, "R6 global off", cons_idx, 3);
        dma_en = 1'b1; ring_en = 1'b0;
        repeat (30) @(negedge clk);
        check(cons_idx == 16'd3 && req_cnt == reqs && cap_n == base, "R6 ring off", cons_idx, 3);
        ring_en = 1'b1;
        wait_cons(16'd4, "R6 resume");
        check_bytes(base, 2, 64'h40, 1'b1, 1'b1, "R6 resumed bytes");
    endtask

    task automatic t_zero();
        logic [31:0] st;
        int base = cap_n;
        int reqs = req_cnt;
        put_desc(8'd4, 0, 3'b111, 64'h80);
        post_prod(16'd5);
        wait_cons(16'd5, "R9 zero advance");
        check(cap_n == base && req_cnt == reqs, "R9 no bytes", cap_n - base, 0);
        read_status(8'd4, st);
        check(st == 32'h0000_6000, "R9 own cleared", st, 32'h0000_6000);
    endtask

    task automatic t_stall(input logic [7:0] slot, input int hold, input bit exp_ur);
        logic [31:0] st;
        logic [7:0]  held;
        int base = cap_n;
        stall_limit = 16'd4;
        put_desc(slot, 3, 3'b111, 64'h500 + 64'(slot));
        @(negedge clk); tx_ready = 1'b0;
        post_prod(16'(slot) + 16'd1);
        for (int i = 0; i < 200 && !tx_valid; i++) @(negedge clk);
        held = tx_data;
        for (int i = 0; i < hold; i++) @(negedge clk);
        check(tx_valid && tx_data == held, "R10 held", tx_data, held);
        tx_ready = 1'b1;
        wait_cons(16'(slot) + 16'd1, "R7 completes");
        check(cap_n - base == 3, "R7 all bytes", cap_n - base, 3);
        check_bytes(base, 3, 64'h500 + 64'(slot), 1'b1, 1'b1, "R7 data");
        read_status(slot, st);
        check(st[9] == exp_ur, "R7 underrun flag", st[9], exp_ur);
        check(st[15] == 1'b0, "R8 own after stall", st[15], 0);
    endtask

    task automatic t_wrap();
        int base;
        @(negedge clk); dma_en = 1'b0;
        @(negedge clk);
        cons_wr_en = 1'b1; cons_wr_data = 16'hFFFE;
        prod_wr_en = 1'b1; prod_wr_data = 16'hFFFE;
        @(negedge clk);
        cons_wr_en = 1'b0; prod_wr_en = 1'b0;
        put_desc(8'd254, 1, 3'b111, 64'hA00);
        put_desc(8'd255, 1, 3'b111, 64'hA10);
        put_desc(8'd0,   1, 3'b111, 64'hA20);
        put_desc(8'd1,   1, 3'b111, 64'hA30);
        base = cap_n;
        post_prod(16'd2);
        @(negedge clk); dma_en = 1'b1;
        wait_cons(16'd2, "R4 index wrap");
        check(cap_n - base == 4, "R4 count", cap_n - base, 4);
        check_bytes(base,     1, 64'hA00, 1'b1, 1'b1, "R4 slot254");
        check_bytes(base + 1, 1, 64'hA10, 1'b1, 1'b1, "R4 slot255");
        check_bytes(base + 2, 1, 64'hA20, 1'b1, 1'b1, "R4 slot0");
        check_bytes(base + 3, 1, 64'hA30, 1'b1, 1'b1, "R4 slot1");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        dma_en = 1'b1; ring_en = 1'b1;
        t_single();
        t_split();
        t_disabled();
        t_zero();
        t_stall(8'd5, 10, 1'b1);
        t_stall(8'd6, 2, 1'b0);
        t_wrap();
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule